// File: doc/BRIEF.md
# Key-Guarded Reset Request Register

This block is a single 32-bit control register on a simple register bus. Software uses it to ask the reset controller for one of two reset scopes: a reset of the processor core alone, or a reset of the whole system. A write has an effect only when its upper half-word carries a fixed unlock key. The same register also holds a small interrupt priority-grouping field. Every accepted write loads that field from the write data, so software that asks for a reset writes the current grouping back in the same word.

An accepted request produces a one-cycle pulse on the matching request output. The block then waits in a pending state until the reset controller answers with an acknowledge. A reset controller may take several cycles to act on a request. During that wait the block masks every interrupt-accept line while the fault-mask input is high, so no new interrupt is taken once the core has chosen to reset.

The control flow is a three-state machine. `ST_IDLE` means no request is outstanding. `ST_CORE_WAIT` means a core-only request was issued and is not yet acknowledged. `ST_SYS_WAIT` means a system request was issued and is not yet acknowledged. It has four transitions. Idle-to-system is taken on an accepted write with bit 2 set. Idle-to-core is taken on an accepted write with bit 0 set and bit 2 clear. Core-wait-to-idle and system-wait-to-idle are each taken when the acknowledge is seen. In every other case the state holds.

Top module: `rstkey_ctrl`

## Requirements
- R1: After reset there is no outstanding request, both request outputs are low, the grouping field is 0, a read of the register returns 0xFA050000, and `irq_accept` follows `irq_in`.
- R2: A write whose bits 31:16 differ from 0x05FA is ignored completely. The grouping field keeps its value and neither request output pulses.
- R3: A write to the register address with key 0x05FA in bits 31:16 loads bits 10:8 into the grouping field. This includes writes that also request a reset.
- R4: An accepted write with bit 0 set and bit 2 clear, made while no request is outstanding, drives `core_req` high for exactly the one cycle after the write edge.
- R5: An accepted write with bit 2 set, made while no request is outstanding, drives `sys_req` high for exactly the one cycle after the write edge.
- R6: When bits 0 and 2 are written together, only `sys_req` pulses. The two request outputs are never high together.
- R7: A request stays outstanding until `rst_ack` is seen high at a clock edge. While it is outstanding, further reset writes produce no pulse. Once it is acknowledged, a new request is accepted.
- R8: While a request is outstanding and `fault_mask` is high, every `irq_accept` bit is 0. Otherwise `irq_accept` equals `irq_in`.
- R9: A read at the register address returns 0xFA05 in bits 31:16 and the grouping field in bits 10:8. All other bits, including the request bits 0 and 2, read 0. A read at any other address returns 0.
- R10: A write to any other address leaves the grouping field unchanged and issues no request, even when it carries the correct key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable |
| bus_rdata | output | 32 | Read data, combinational from address |
| core_req | output | 1 | One-cycle core-only reset request |
| sys_req | output | 1 | One-cycle full system reset request |
| rst_ack | input | 1 | Acknowledge from the reset controller |
| fault_mask | input | 1 | Fault-mask level from the core |
| irq_in | input | IRQ_W | Interrupt-accept requests |
| irq_accept | output | IRQ_W | Gated interrupt-accept lines |

## Verification
The bench builds the block with IRQ_W = 8 and REG_ADDR = 0x2A4 instead of the defaults. The wider interrupt vector shows that gating reaches every line produced by the generate loop, not only the low ones. The non-default address makes the decode compare against a value that differs from the default in several bits. Writes and reads to a neighbouring address then show that the decode has no effect outside its one word.

// File: rtl/rstkey_pkg.sv
package rstkey_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_CORE_WAIT = 2'd1,
        ST_SYS_WAIT  = 2'd2
    } rq_state_e;

    typedef struct packed {
        logic hit;
        logic want_core;
        logic want_sys;
    } wr_dec_t;

    localparam int DATA_W   = 32;
    localparam int KEY_W    = 16;
    localparam int KEY_LSB  = DATA_W - KEY_W;
    localparam int CORE_BIT = 0;
    localparam int SYS_BIT  = 2;

endpackage

// File: rtl/rstkey_decode.sv
module rstkey_decode
    import rstkey_pkg::*;
#(
    parameter int                 ADDR_W   = 12,
    parameter logic [ADDR_W-1:0]  REG_ADDR = 12'h10C,
    parameter logic [KEY_W-1:0]   WR_KEY   = 16'h05FA,
    parameter int                 PRI_W    = 3,
    parameter int                 PRI_LSB  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    output wr_dec_t           dec,
    output logic [PRI_W-1:0]  pri_new
);

    localparam logic [DATA_W-1:0] PRI_MASK  = ((DATA_W'(1) << PRI_W) - DATA_W'(1)) << PRI_LSB;
    localparam logic [DATA_W-1:0] KEY_MASK  = ((DATA_W'(1) << KEY_W) - DATA_W'(1)) << KEY_LSB;
    localparam logic [DATA_W-1:0] REQ_MASK  = (DATA_W'(1) << CORE_BIT) | (DATA_W'(1) << SYS_BIT);
    localparam logic [DATA_W-1:0] USED_MASK = PRI_MASK | KEY_MASK | REQ_MASK;

    logic addr_ok;
    logic key_ok;
    logic unused_bits;

    assign addr_ok     = (addr == REG_ADDR);
    assign key_ok      = (wdata[KEY_LSB +: KEY_W] == WR_KEY);
    assign unused_bits = ^(wdata & ~USED_MASK);

    always_comb begin
        dec.hit       = we && addr_ok && key_ok;
        dec.want_sys  = dec.hit && wdata[SYS_BIT];
        dec.want_core = dec.hit && wdata[CORE_BIT] && !wdata[SYS_BIT];
        pri_new       = wdata[PRI_LSB +: PRI_W];
    end

endmodule

// File: rtl/rstkey_regs.sv
module rstkey_regs
    import rstkey_pkg::*;
#(
    parameter int                 ADDR_W   = 12,
    parameter logic [ADDR_W-1:0]  REG_ADDR = 12'h10C,
    parameter logic [KEY_W-1:0]   RD_SIG   = 16'hFA05,
    parameter int                 PRI_W    = 3,
    parameter int                 PRI_LSB  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_dec_t           dec,
    input  logic [PRI_W-1:0]  pri_new,
    input  logic [ADDR_W-1:0] addr,
    output logic [PRI_W-1:0]  pri_q,
    output logic [DATA_W-1:0] rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pri_q <= '0;
        end else if (dec.hit) begin
            pri_q <= pri_new;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == REG_ADDR) begin
            rdata[KEY_LSB +: KEY_W] = RD_SIG;
            rdata[PRI_LSB +: PRI_W] = pri_q;
        end
    end

endmodule

// File: rtl/rstkey_fsm.sv
module rstkey_fsm
    import rstkey_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  wr_dec_t dec,
    input  logic    rst_ack,
    output logic    core_req,
    output logic    sys_req,
    output logic    pending
);

    rq_state_e state_q;
    rq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (dec.want_sys) begin
                    state_d = ST_SYS_WAIT;
                end else if (dec.want_core) begin
                    state_d = ST_CORE_WAIT;
                end
            end
            ST_CORE_WAIT: begin
                if (rst_ack) begin
                    state_d = ST_IDLE;
                end
            end
            ST_SYS_WAIT: begin
                if (rst_ack) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_req <= 1'b0;
            sys_req  <= 1'b0;
        end else begin
            core_req <= (state_q == ST_IDLE) && (state_d == ST_CORE_WAIT);
            sys_req  <= (state_q == ST_IDLE) && (state_d == ST_SYS_WAIT);
        end
    end

    assign pending = (state_q != ST_IDLE);

endmodule

// File: rtl/rstkey_irqgate.sv
module rstkey_irqgate #(
    parameter int IRQ_W = 4
) (
    input  logic             pending,
    input  logic             fault_mask,
    input  logic [IRQ_W-1:0] irq_in,
    output logic [IRQ_W-1:0] irq_accept
);

    logic hold_off;
    assign hold_off = pending && fault_mask;

    for (genvar i = 0; i < IRQ_W; i++) begin : g_line
        assign irq_accept[i] = irq_in[i] && !hold_off;
    end

endmodule

// File: rtl/rstkey_ctrl.sv
module rstkey_ctrl
    import rstkey_pkg::*;
#(
    parameter int                 ADDR_W   = 12,
    parameter logic [ADDR_W-1:0]  REG_ADDR = 12'h10C,
    parameter logic [15:0]        WR_KEY   = 16'h05FA,
    parameter logic [15:0]        RD_SIG   = 16'hFA05,
    parameter int                 PRI_W    = 3,
    parameter int                 PRI_LSB  = 8,
    parameter int                 IRQ_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata,
    output logic              core_req,
    output logic              sys_req,
    input  logic              rst_ack,
    input  logic              fault_mask,
    input  logic [IRQ_W-1:0]  irq_in,
    output logic [IRQ_W-1:0]  irq_accept
);

    wr_dec_t          dec;
    logic [PRI_W-1:0] pri_new;
    logic [PRI_W-1:0] pri_q;
    logic             pending;

    rstkey_decode #(
        .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .WR_KEY(WR_KEY),
        .PRI_W(PRI_W), .PRI_LSB(PRI_LSB)
    ) u_dec (
        .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
        .dec(dec), .pri_new(pri_new)
    );

    rstkey_regs #(
        .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .RD_SIG(RD_SIG),
        .PRI_W(PRI_W), .PRI_LSB(PRI_LSB)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .dec(dec), .pri_new(pri_new),
        .addr(bus_addr), .pri_q(pri_q), .rdata(bus_rdata)
    );

    rstkey_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .dec(dec), .rst_ack(rst_ack),
        .core_req(core_req), .sys_req(sys_req), .pending(pending)
    );

    rstkey_irqgate #(.IRQ_W(IRQ_W)) u_gate (
        .pending(pending), .fault_mask(fault_mask),
        .irq_in(irq_in), .irq_accept(irq_accept)
    );

endmodule

// File: rtl/rstkey_chk.sv
module rstkey_chk #(
    parameter int                 ADDR_W   = 12,
    parameter logic [ADDR_W-1:0]  REG_ADDR = 12'h10C,
    parameter logic [15:0]        WR_KEY   = 16'h05FA,
    parameter int                 PRI_W    = 3,
    parameter int                 PRI_LSB  = 8,
    parameter int                 IRQ_W    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_we,
    input logic [31:0]       bus_rdata,
    input logic              core_req,
    input logic              sys_req,
    input logic              rst_ack,
    input logic              fault_mask,
    input logic [IRQ_W-1:0]  irq_accept,
    input logic [PRI_W-1:0]  pri_q,
    input logic              pending
);

    logic good_wr;
    assign good_wr = bus_we && (bus_addr == REG_ADDR) && (bus_wdata[31:16] == WR_KEY);

    p_key_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_wdata[31:16] != WR_KEY) |=> $stable(pri_q));

    p_key_noreq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_wdata[31:16] != WR_KEY) |=> (!core_req && !sys_req));

    p_pri_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        good_wr |=> (pri_q == $past(bus_wdata[PRI_LSB +: PRI_W])));

    p_core_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (good_wr && !pending && bus_wdata[0] && !bus_wdata[2]) |=> (core_req && !sys_req));

    p_sys_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (good_wr && !pending && bus_wdata[2]) |=> (sys_req && !core_req));

    p_one_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({core_req, sys_req}));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !rst_ack) |=> pending);

    p_no_repulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> (!core_req && !sys_req));

    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && fault_mask) |-> (irq_accept == '0));

    p_req_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[0] == 1'b0) && (bus_rdata[2] == 1'b0));

    p_addr_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr != REG_ADDR) |=> ($stable(pri_q) && !core_req && !sys_req));

endmodule

bind rstkey_ctrl rstkey_chk #(
    .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .WR_KEY(WR_KEY),
    .PRI_W(PRI_W), .PRI_LSB(PRI_LSB), .IRQ_W(IRQ_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .core_req(core_req),
    .sys_req(sys_req), .rst_ack(rst_ack), .fault_mask(fault_mask),
    .irq_accept(irq_accept), .pri_q(pri_q), .pending(pending)
);

// File: tb/sim_rstkey_ctrl.sv
`timescale 1ns/1ps
module sim_rstkey_ctrl;

    localparam int          AW   = 12;
    localparam logic [11:0] RADR = 12'h2A4;
    localparam int          IW   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_rdata;
    logic          core_req, sys_req;
    logic          rst_ack = 1'b0;
    logic          fault_mask = 1'b0;
    logic [IW-1:0] irq_in = '0;
    logic [IW-1:0] irq_accept;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // scoreboard items: 1 = core pulse, 2 = system pulse
    int exp_q[$];

    always #2.5 clk = ~clk;

    rstkey_ctrl #(.ADDR_W(AW), .REG_ADDR(RADR), .IRQ_W(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .core_req(core_req),
        .sys_req(sys_req), .rst_ack(rst_ack), .fault_mask(fault_mask),
        .irq_in(irq_in), .irq_accept(irq_accept)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compares every observed request pulse with the scoreboard
    always @(negedge clk) begin
        if (rst_n && (core_req || sys_req)) begin
            int got;
            got = sys_req ? 2 : 1;
            if (core_req && sys_req) got = 3;
            if (exp_q.size() == 0) begin
                check("R2/R7/R10 unexpected pulse", 32'(got), 32'd0);
            end else begin
                int e;
                e = exp_q.pop_front();
                check("R4/R5/R6 pulse kind", 32'(got), 32'(e));
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input int expect_kind);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        if (expect_kind != 0) exp_q.push_back(expect_kind);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = RADR;
        @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string req, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 check(req, bus_rdata, exp);
    endtask

    task automatic ack();
        @(negedge clk); rst_ack = 1'b1;
        @(negedge clk); rst_ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        irq_in = 8'hA5;
        bus_addr = RADR;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        check("R1 rdata", bus_rdata, 32'hFA05_0000);
        check("R1 req", {30'd0, core_req, sys_req}, 32'd0);
        check("R1 irq", 32'(irq_accept), 32'hA5);

        // R3 plain grouping write
        wr(RADR, 32'h05FA_0500, 0);
        rd(RADR, "R3 load", 32'hFA05_0500);

        // R2 wrong key with request bits and new grouping
        wr(RADR, 32'h1234_0205, 0);
        rd(RADR, "R2 ignored", 32'hFA05_0500);

        // R10 other address, valid key
        wr(RADR ^ 12'h004, 32'h05FA_0105, 0);
        rd(RADR, "R10 ignored", 32'hFA05_0500);

        // R4 core request, keeping the grouping field
        wr(RADR, 32'h05FA_0501, 1);
        rd(RADR, "R9 req bits read 0", 32'hFA05_0500);
        fault_mask = 1'b1; irq_in = 8'hFF;
        #1 check("R8 gated", 32'(irq_accept), 32'd0);
        fault_mask = 1'b0;
        #1 check("R8 unmasked", 32'(irq_accept), 32'hFF);
        // R7 second request while pending gives no pulse
        wr(RADR, 32'h05FA_0504, 0);
        repeat (4) @(negedge clk);
        fault_mask = 1'b1;
        #1 check("R7 still pending", 32'(irq_accept), 32'd0);
        ack();
        #1 check("R8 released after ack", 32'(irq_accept), 32'hFF);
        fault_mask = 1'b0;

        // R5 system request with new grouping (R3)
        wr(RADR, 32'h05FA_0304, 2);
        rd(RADR, "R3 reset write loads field", 32'hFA05_0300);
        ack();

        // R6 both bits
        wr(RADR, 32'h05FA_0705, 2);
        rd(RADR, "R6 field", 32'hFA05_0700);
        ack();

        // R9 other address reads zero
        rd(RADR ^ 12'h004, "R9 other addr", 32'd0);

        repeat (3) @(negedge clk);
        check("R4/R5/R6 all pulses seen", 32'(exp_q.size()), 32'd0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule